// File: doc/BRIEF.md
# Link Width Fallback and Lane Reversal Sequencer

This block runs link-width negotiation for a single port that may be programmed anywhere from x1 to x16. It caps the first trial at the narrower of the local programmed width and the width the partner advertises. It offers each width to the training logic in turn, and steps down by halves whenever a trial fails or times out. Before a width is offered, its lanes are checked against a per-lane good/broken vector, so a width that would touch a broken lane is skipped without spending a trial on it.

When every width has failed in normal lane order, the block flips the lane orientation and runs the whole descending sequence again. In normal order the lowest lane of the port faces the partner's lane 0. In reversed order the highest lane of the programmed span faces it. Success latches the width and the orientation and raises link-up. If both passes are used up, the block parks in a link-down state. A retrain pulse restarts negotiation from either end state, or from the middle of a sequence.

Top module: `link_width_fallback`

## Requirements
- R1: After reset, `trial_req`, `link_up` and `link_down` are all low, and they stay low until `retrain` is pulsed.
- R2: A width code k means x(2^k), for k from 0 to 4. Codes above 4 on `prog_width` or `partner_width` act as 4. The first width considered after `retrain` is the smaller of the two clamped codes.
- R3: A width W is offered only if every lane it occupies is good in `lane_good`. With P the clamped programmed width, normal order occupies lanes 0 to W-1 and reversed order occupies lanes P-W to P-1.
- R4: Candidates run from the cap down to code 0 in normal order, and then from the cap down to code 0 in reversed order. Each eligible candidate is offered once, and ineligible ones are skipped without raising `trial_req`.
- R5: If `trial_pass` is seen while `trial_req` is high, then on the next cycle `link_up` goes high, and `link_width` and `link_reversed` hold the width and orientation of that trial.
- R6: `trial_fail`, or `TIMEOUT` consecutive cycles of `trial_req` with no response, ends the trial and moves on to the next candidate.
- R7: If the reversed pass runs out of candidates without a pass, `link_down` goes high and stays high until `retrain`.
- R8: While `link_up` is high, `link_width` and `link_reversed` do not change, and `lane_good`, `trial_pass` and `trial_fail` have no effect, until `retrain`.
- R9: A `retrain` pulse in any state clears `link_up`, `link_down` and `trial_req` on the next cycle. Negotiation then restarts at the cap in normal order.
- R10: If `trial_pass` and `trial_fail` arrive in the same cycle, the pass wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retrain | input | 1 | Starts or restarts negotiation |
| prog_width | input | 3 | Programmed width code (log2 of lanes), held stable during negotiation |
| partner_width | input | 3 | Partner maximum width code, held stable during negotiation |
| lane_good | input | 16 | Per-lane good flag, where 1 means usable |
| trial_pass | input | 1 | Training at the offered width succeeded |
| trial_fail | input | 1 | Training at the offered width failed |
| trial_req | output | 1 | A trial is in progress |
| trial_width | output | 3 | Width code under trial |
| trial_reversed | output | 1 | Orientation under trial, where 1 means reversed |
| link_up | output | 1 | Link trained |
| link_down | output | 1 | All candidates exhausted |
| link_width | output | 3 | Trained width code |
| link_reversed | output | 1 | Trained orientation |

## Verification
The bench sweeps every programmed width against several partner widths, including an oversized code, and pairs each with broken-lane patterns at lane 0, at the top lane and at middle lanes. For each case it compares the whole sequence of offered trials with an arithmetic model. A design that measured the reversed window from the cap instead of from the programmed span, that skipped the reversed pass, or that spent a trial on a broken width would offer the wrong trial at some point in that sequence. Silent-partner runs measure the timeout length, which catches an off-by-one in the timer. Other runs deliver pass and fail together, toggle the inputs while the link is up, and pulse retrain mid-trial, which catches a sequencer that lets fail win, lets a latched result drift, or resumes where it left off after a retrain.

// File: rtl/lwf_pkg.sv
package lwf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SELECT,
    ST_TRIAL,
    ST_UP,
    ST_DOWN
  } lwf_state_e;
endpackage

// File: rtl/lwf_lane_window.sv
// Decides whether a candidate width only touches good lanes in the current orientation.
module lwf_lane_window #(
  parameter int MAX_LANES = 16,
  parameter int CW        = 3
) (
  input  logic [MAX_LANES-1:0] lane_good,
  input  logic [CW-1:0]        span_code,
  input  logic [CW-1:0]        try_code,
  input  logic                 try_rev,
  output logic                 eligible
);
  localparam int LW = $clog2(MAX_LANES) + 1;

  logic [LW-1:0]        span_lanes;
  logic [LW-1:0]        try_lanes;
  logic [LW-1:0]        rev_base;
  logic [MAX_LANES-1:0] used;

  assign span_lanes = LW'(1) << span_code;
  assign try_lanes  = LW'(1) << try_code;
  assign rev_base   = span_lanes - try_lanes;

  for (genvar i = 0; i < MAX_LANES; i++) begin : g_lane
    assign used[i] = try_rev ? ((LW'(i) >= rev_base) && (LW'(i) < span_lanes))
                             : (LW'(i) < try_lanes);
  end

  assign eligible = &(~used | lane_good);
endmodule

// File: rtl/lwf_trial_timer.sv
// Counts cycles of one trial and flags expiry after TIMEOUT cycles.
module lwf_trial_timer #(
  parameter int TIMEOUT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int TW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign expired = run && (cnt_q == TW'(TIMEOUT - 1));

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!run) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (!expired) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assert_timer_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TW'(TIMEOUT - 1));
endmodule

// File: rtl/link_width_fallback.sv
module link_width_fallback
  import lwf_pkg::*;
#(
  parameter  int MAX_LANES = 16,
  parameter  int TIMEOUT   = 64,
  localparam int LOG_MAX   = $clog2(MAX_LANES),
  localparam int CW        = $clog2(LOG_MAX + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 retrain,
  input  logic [CW-1:0]        prog_width,
  input  logic [CW-1:0]        partner_width,
  input  logic [MAX_LANES-1:0] lane_good,
  input  logic                 trial_pass,
  input  logic                 trial_fail,
  output logic                 trial_req,
  output logic [CW-1:0]        trial_width,
  output logic                 trial_reversed,
  output logic                 link_up,
  output logic                 link_down,
  output logic [CW-1:0]        link_width,
  output logic                 link_reversed
);
  lwf_state_e    state_q, state_d;
  logic [CW-1:0] cur_q, cur_d;
  logic          rev_q, rev_d;
  logic [CW-1:0] lw_q, lw_d;
  logic          lr_q, lr_d;
  logic          lnk_en;
  logic [CW-1:0] prog_c, part_c, cap;
  logic          eligible, expired;
  lwf_state_e    adv_state;
  logic [CW-1:0] adv_cur;
  logic          adv_rev;

  assign prog_c = (prog_width    > CW'(LOG_MAX)) ? CW'(LOG_MAX) : prog_width;
  assign part_c = (partner_width > CW'(LOG_MAX)) ? CW'(LOG_MAX) : partner_width;
  assign cap    = (part_c < prog_c) ? part_c : prog_c;

  lwf_lane_window #(.MAX_LANES(MAX_LANES), .CW(CW)) win_i (
    .lane_good (lane_good),
    .span_code (prog_c),
    .try_code  (cur_q),
    .try_rev   (rev_q),
    .eligible  (eligible)
  );

  lwf_trial_timer #(.TIMEOUT(TIMEOUT)) tmr_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (state_q == ST_TRIAL),
    .expired (expired)
  );

  // Next candidate after a skip or a failed trial.
  always_comb begin
    adv_state = ST_SELECT;
    adv_cur   = cur_q;
    adv_rev   = rev_q;
    if (cur_q != '0) begin
      adv_cur = cur_q - CW'(1);
    end else if (!rev_q) begin
      adv_cur = cap;
      adv_rev = 1'b1;
    end else begin
      adv_state = ST_DOWN;
    end
  end

  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    rev_d   = rev_q;
    lnk_en  = 1'b0;
    lw_d    = lw_q;
    lr_d    = lr_q;
    unique case (state_q)
      ST_SELECT: begin
        if (eligible) begin
          state_d = ST_TRIAL;
        end else begin
          state_d = adv_state;
          cur_d   = adv_cur;
          rev_d   = adv_rev;
        end
      end
      ST_TRIAL: begin
        if (trial_pass) begin
          state_d = ST_UP;
          lnk_en  = 1'b1;
          lw_d    = cur_q;
          lr_d    = rev_q;
        end else if (trial_fail || expired) begin
          state_d = adv_state;
          cur_d   = adv_cur;
          rev_d   = adv_rev;
        end
      end
      default: ;
    endcase
    if (retrain) begin
      state_d = ST_SELECT;
      cur_d   = cap;
      rev_d   = 1'b0;
      lnk_en  = 1'b1;
      lw_d    = '0;
      lr_d    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      rev_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      rev_q   <= rev_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lw_q <= '0;
      lr_q <= 1'b0;
    end else if (lnk_en) begin
      lw_q <= lw_d;
      lr_q <= lr_d;
    end
  end

  assign trial_req      = (state_q == ST_TRIAL);
  assign trial_width    = cur_q;
  assign trial_reversed = rev_q;
  assign link_up        = (state_q == ST_UP);
  assign link_down      = (state_q == ST_DOWN);
  assign link_width     = lw_q;
  assign link_reversed  = lr_q;

  assert_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trial_req, link_up, link_down}));
  assert_width_capped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    trial_req |-> trial_width <= cap);
  assert_trial_eligible_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trial_req |-> eligible);
  assert_pass_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trial_req && trial_pass && !retrain |=> link_up && link_width == $past(trial_width)
      && link_reversed == $past(trial_reversed));
  assert_down_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    link_down && !retrain |=> link_down);
  assert_up_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    link_up && !retrain |=> link_up && $stable(link_width) && $stable(link_reversed));
  assert_retrain_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    retrain |=> !link_up && !link_down && !trial_req);
  assert_pass_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trial_req && trial_pass && trial_fail && !retrain |=> link_up);
endmodule

// File: tb/link_width_fallback_tb_top.sv
module link_width_fallback_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LANES      = 16;
  localparam int TO         = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             retrain;
  logic [2:0]       prog_width, partner_width;
  logic [LANES-1:0] lane_good;
  logic             trial_pass, trial_fail;
  logic             trial_req, trial_reversed, link_up, link_down, link_reversed;
  logic [2:0]       trial_width, link_width;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  link_width_fallback #(.MAX_LANES(LANES), .TIMEOUT(TO)) dut_i (
    .clk(clk), .rst_n(rst_n), .retrain(retrain),
    .prog_width(prog_width), .partner_width(partner_width), .lane_good(lane_good),
    .trial_pass(trial_pass), .trial_fail(trial_fail),
    .trial_req(trial_req), .trial_width(trial_width), .trial_reversed(trial_reversed),
    .link_up(link_up), .link_down(link_down),
    .link_width(link_width), .link_reversed(link_reversed)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clampw(input int v);
    return (v > 4) ? 4 : v;
  endfunction

  function automatic bit elig(input int p, input int w, input bit rev, input logic [LANES-1:0] g);
    int span = 1 << p;
    int wl   = 1 << w;
    int lo   = rev ? span - wl : 0;
    for (int i = lo; i < lo + wl; i++) if (!g[i]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic run_case(input int p, input int q, input logic [LANES-1:0] good,
                          input int acc_n, input int acc_r, input bit silent, input bit both);
    int  cap, nexp, win, idx, tcyc, guard, ntr, acc;
    int  exp_c[10];
    bit  exp_r[10];
    bit  prev_req, seq_ok, to_checked, ok;
    cap = clampw(p) < clampw(q) ? clampw(p) : clampw(q);
    nexp = 0; win = -1;
    for (int r = 0; r < 2; r++)
      for (int c = cap; c >= 0; c--)
        if (elig(clampw(p), c, r[0], good)) begin
          exp_c[nexp] = c; exp_r[nexp] = r[0];
          if (win < 0 && !silent && c <= (r != 0 ? acc_r : acc_n)) win = nexp;
          nexp++;
        end
    ntr = (win >= 0) ? win + 1 : nexp;
    @(negedge clk);
    prog_width = 3'(p); partner_width = 3'(q); lane_good = good;
    trial_pass = 1'b0; trial_fail = 1'b0; retrain = 1'b1;
    @(negedge clk);
    retrain = 1'b0;
    chk(!link_up && !link_down && !trial_req, "R9 restart clears", int'(link_up) + int'(link_down), 0);
    idx = 0; tcyc = 0; guard = 0; prev_req = 1'b0; seq_ok = 1'b1; to_checked = 1'b0;
    while (!(link_up || link_down) && guard < 600) begin
      if (trial_req) begin
        if (!prev_req) begin
          if (idx >= nexp || int'(trial_width) != exp_c[idx] || trial_reversed != exp_r[idx]) seq_ok = 1'b0;
          if (idx == 0) chk(nexp > 0 && int'(trial_width) == exp_c[0], "R2 first trial width",
                            int'(trial_width), nexp > 0 ? exp_c[0] : -1);
          idx++; tcyc = 0;
        end
        tcyc++;
        acc = trial_reversed ? acc_r : acc_n;
        ok = !silent && (int'(trial_width) <= acc);
        trial_pass = ok;
        trial_fail = (!silent && !ok) || (both && ok);
      end else begin
        if (prev_req && silent && !to_checked) begin
          chk(tcyc == TO, "R6 timeout length", tcyc, TO);
          to_checked = 1'b1;
        end
        trial_pass = 1'b0; trial_fail = 1'b0;
      end
      prev_req = trial_req;
      @(negedge clk);
      guard++;
    end
    trial_pass = 1'b0; trial_fail = 1'b0;
    chk(seq_ok && idx == ntr, "R3/R4 trial sequence and count", idx, ntr);
    if (win >= 0)
      chk(link_up && int'(link_width) == exp_c[win] && link_reversed == exp_r[win],
          "R5 trained width/orientation", int'(link_width) * 2 + int'(link_reversed),
          exp_c[win] * 2 + int'(exp_r[win]));
    else
      chk(link_down && !link_up, "R7 link down after both passes", int'(link_down), 1);
  endtask

  initial begin
    logic [LANES-1:0] pats[8];
    int qs[5];
    logic [2:0] w0;
    logic r0;
    pats = '{16'hFFFF, 16'hFFFE, 16'h7FFF, 16'hFFFB, 16'hBFFD, 16'hFF7F, 16'hFF00, 16'hFFF7};
    qs   = '{0, 1, 3, 4, 7};
    rst_n = 1'b0; retrain = 1'b0; prog_width = '0; partner_width = '0;
    lane_good = '1; trial_pass = 1'b0; trial_fail = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!trial_req && !link_up && !link_down, "R1 idle after reset",
          int'(trial_req) + int'(link_up) + int'(link_down), 0);
    end

    // Main sweep: widths, partners, lane faults, acceptance profiles.
    for (int p = 0; p < 5; p++)
      for (int qi = 0; qi < 5; qi++)
        for (int g = 0; g < 8; g++) begin
          run_case(p, qs[qi], pats[g], 4, 4, 1'b0, 1'b0);
          run_case(p, qs[qi], pats[g], -1, 4, 1'b0, 1'b0);
          run_case(p, qs[qi], pats[g], 1, -1, 1'b0, 1'b0);
          run_case(p, qs[qi], pats[g], -1, -1, 1'b0, 1'b0);
        end
    // Silent partner: every trial times out (R6).
    for (int p = 0; p < 5; p++)
      for (int qi = 0; qi < 5; qi++) run_case(p, qs[qi], pats[qi], 4, 4, 1'b1, 1'b0);
    // R10: pass and fail together on accepted trials.
    for (int g = 0; g < 8; g++) run_case(4, 4, pats[g], 2, 3, 1'b0, 1'b1);

    // R8: latched result ignores inputs while up.
    run_case(4, 4, 16'hFFFE, -1, 2, 1'b0, 1'b0);
    w0 = link_width; r0 = link_reversed;
    for (int k = 0; k < 6; k++) begin
      lane_good = k[0] ? '0 : 16'h1234;
      trial_pass = k[0]; trial_fail = !k[0];
      @(negedge clk);
      chk(link_up && link_width == w0 && link_reversed == r0, "R8 stable while up",
          int'(link_width), int'(w0));
    end
    trial_pass = 1'b0; trial_fail = 1'b0;

    // R7: link down holds against responses.
    run_case(3, 4, 16'hFFFF, -1, -1, 1'b0, 1'b0);
    for (int k = 0; k < 5; k++) begin
      trial_pass = 1'b1;
      @(negedge clk);
      chk(link_down && !link_up, "R7 down held", int'(link_down), 1);
    end
    trial_pass = 1'b0;

    // R9: retrain in the middle of a trial restarts at the cap, normal order.
    prog_width = 3'd3; partner_width = 3'd4; lane_good = '1; retrain = 1'b1;
    @(negedge clk); retrain = 1'b0;
    while (!trial_req) @(negedge clk);
    repeat (3) @(negedge clk);
    retrain = 1'b1;
    @(negedge clk); retrain = 1'b0;
    chk(!trial_req, "R9 trial aborted", int'(trial_req), 0);
    @(negedge clk);
    chk(trial_req && trial_width == 3'd3 && !trial_reversed, "R9 restart at cap",
        int'(trial_width), 3);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog (R1-R10 run incomplete) actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule